// File: doc/BRIEF.md
# Page-mapped byte DMA engine

This block is a single-channel DMA engine. It moves bytes one at a time between one peripheral and a byte-wide memory port. Software loads a few things before it starts a transfer: a page table that turns a short page tag into a physical frame number, a starting tag, a byte offset within the page, and a byte count. It then sets the enable and direction bits. Each cycle in which the peripheral holds its request line high, the engine moves one byte. It then steps the offset, and steps the tag whenever the offset runs past the end of a page. It stops by itself when the count reaches zero.

The peripheral's interrupt line does not go straight to the CPU. It passes through a pending bit in the engine's status word, and the engine's interrupt output is a registered copy of that bit. A soft reset, requested through a bit of the control word, clears the channel. It leaves the page table and the pending interrupt alone.

Top module: `pmdma_engine`

## Requirements
- R1: The register write select codes are 0 for control, 1 for count, 2 for page tag and 3 for byte offset. In the control word, bit0 is enable, bit1 is direction (1 means device to memory) and bit2 is soft reset. `stat_o` shows enable in bit0, direction in bit1, interrupt pending in bit3 and count-zero in bit4. Bit2 of `stat_o` is always 0.
- R2: During a transfer, the memory address is the page-table frame selected by the tag, shifted left by 12 bits, ORed with the 12-bit offset.
- R3: A byte moves in a cycle only when all of these hold: the request line is high, enable is set, the count is nonzero, and no register write is presented in that cycle.
- R4: With direction 1, the transfer cycle pulses `dev_rd_o` and `mem_we_o` together, and `mem_wdata_o` carries `dev_rdata_i`.
- R5: With direction 0, the transfer cycle pulses `mem_re_o` and `dev_wr_o` together, and `dev_wdata_o` carries `mem_rdata_i`.
- R6: After each byte, the count is one lower and the offset is one higher, visible in the next cycle.
- R7: When the offset wraps from 0xFFF to 0x000, the tag increments in the same step, wrapping from 127 to 0.
- R8: The byte that brings the count to zero clears enable and sets count-zero. `int_o` does not change because of it.
- R9: One cycle after `irq_i` changes, the pending status bit and `int_o` take its level.
- R10: A control write with bit2 set clears enable, direction, count, tag, offset and count-zero. It keeps the pending bit and the page table.
- R11: While the request line stays high and the count allows, one byte moves every clock.
- R12: After hardware reset, the status word, count, tag and offset are zero and `int_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 24 | Register write data |
| map_wr_i | input | 1 | Page-table write strobe |
| map_idx_i | input | 7 | Page-table entry index |
| map_frame_i | input | 20 | Frame number to store |
| drq_i | input | 1 | Peripheral transfer request |
| irq_i | input | 1 | Peripheral interrupt level |
| dev_rdata_i | input | 8 | Byte from the peripheral |
| dev_rd_o | output | 1 | Peripheral read strobe |
| dev_wr_o | output | 1 | Peripheral write strobe |
| dev_wdata_o | output | 8 | Byte to the peripheral |
| mem_addr_o | output | 32 | Physical byte address |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Byte to memory |
| mem_rdata_i | input | 8 | Byte from memory (combinational) |
| int_o | output | 1 | Interrupt to the CPU |
| stat_o | output | 5 | Status word |
| cnt_o | output | 24 | Remaining count |
| tag_o | output | 7 | Current page tag |
| off_o | output | 12 | Current byte offset |

## Verification
The strobes, the address and the data lines respond in the same cycle as the request. The scoreboard monitor therefore compares them at the falling edge of the cycle in which the driver raised `drq_i`. Count, offset, tag, status and `int_o` are registered and change one clock after the transfer, register write or `irq_i` change that causes them. The bench reads them after the next rising edge and never in the stimulus cycle itself. An unexpected strobe finds the expected-item queue empty and is reported, which covers the cases that must not move a byte.

// File: rtl/pmdma_pkg.sv
package pmdma_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_TAG    = 2'd2,
        SEL_OFFSET = 2'd3
    } reg_sel_e;

    localparam int CTRL_EN  = 0;
    localparam int CTRL_DIR = 1;
    localparam int CTRL_RST = 2;

    localparam int ST_W    = 5;
    localparam int ST_EN   = 0;
    localparam int ST_DIR  = 1;
    localparam int ST_PEND = 3;
    localparam int ST_TCZ  = 4;
endpackage

// File: rtl/pmdma_page_map.sv
module pmdma_page_map #(
    parameter int TAG_W   = 7,
    parameter int FRAME_W = 20
) (
    input  logic               clk,
    input  logic               wr_i,
    input  logic [TAG_W-1:0]   widx_i,
    input  logic [FRAME_W-1:0] wframe_i,
    input  logic [TAG_W-1:0]   ridx_i,
    output logic [FRAME_W-1:0] rframe_o
);
    localparam int DEPTH = 1 << TAG_W;

    // Table contents survive every reset; software owns them.
    logic [FRAME_W-1:0] frame_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_i) frame_q[widx_i] <= wframe_i;
    end

    assign rframe_o = frame_q[ridx_i];
endmodule

// File: rtl/pmdma_irq_relay.sv
module pmdma_irq_relay (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_i,
    output logic pend_o
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = irq_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i |=> pend_o);
    p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_i |=> !pend_o);
endmodule

// File: rtl/pmdma_chan_regs.sv
module pmdma_chan_regs
    import pmdma_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int TAG_W = 7,
    parameter int OFF_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_i,
    input  reg_sel_e         reg_sel_i,
    input  logic [CNT_W-1:0] reg_wdata_i,
    input  logic             drq_i,
    output logic             go_o,
    output logic             en_o,
    output logic             dir_o,
    output logic             tcz_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [TAG_W-1:0] tag_o,
    output logic [OFF_W-1:0] off_o
);
    typedef struct packed {
        logic             en;
        logic             dir;
        logic             tcz;
        logic [CNT_W-1:0] cnt;
        logic [TAG_W-1:0] tag;
        logic [OFF_W-1:0] off;
    } chan_t;

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [TAG_W-1:0] TAG_ONE = TAG_W'(1);
    localparam logic [OFF_W-1:0] OFF_MAX = '1;

    chan_t st_d, st_q;
    logic  go;
    logic  carry;
    logic [OFF_W-1:0] off_inc;

    always_comb begin
        go            = drq_i && st_q.en && (st_q.cnt != '0) && !reg_wr_i;
        {carry, off_inc} = {1'b0, st_q.off} + {{OFF_W{1'b0}}, 1'b1};
        st_d          = st_q;
        if (go) begin
            st_d.cnt = st_q.cnt - CNT_ONE;
            st_d.off = off_inc;
            if (carry) st_d.tag = st_q.tag + TAG_ONE;
            if (st_q.cnt == CNT_ONE) begin
                st_d.en  = 1'b0;
                st_d.tcz = 1'b1;
            end
        end
        if (reg_wr_i) begin
            unique case (reg_sel_i)
                SEL_CTRL: begin
                    if (reg_wdata_i[CTRL_RST]) begin
                        st_d = '0;
                    end else begin
                        st_d.en  = reg_wdata_i[CTRL_EN];
                        st_d.dir = reg_wdata_i[CTRL_DIR];
                    end
                end
                SEL_COUNT:  st_d.cnt = reg_wdata_i;
                SEL_TAG:    st_d.tag = reg_wdata_i[TAG_W-1:0];
                SEL_OFFSET: st_d.off = reg_wdata_i[OFF_W-1:0];
                default:    st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign go_o  = go;
    assign en_o  = st_q.en;
    assign dir_o = st_q.dir;
    assign tcz_o = st_q.tcz;
    assign cnt_o = st_q.cnt;
    assign tag_o = st_q.tag;
    assign off_o = st_q.off;

    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (st_q.cnt == $past(st_q.cnt) - CNT_ONE));
    p_page_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (go && st_q.off == OFF_MAX) |=> (st_q.tag == $past(st_q.tag) + TAG_ONE) && (st_q.off == '0));
    p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (go && st_q.cnt == CNT_ONE) |=> (!st_q.en && st_q.tcz));
    p_soft_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_sel_i == SEL_CTRL && reg_wdata_i[CTRL_RST])
        |=> (st_q.cnt == '0 && st_q.tag == '0 && st_q.off == '0 && !st_q.en && !st_q.tcz));
endmodule

// File: rtl/pmdma_engine.sv
module pmdma_engine
    import pmdma_pkg::*;
#(
    parameter int CNT_W   = 24,
    parameter int TAG_W   = 7,
    parameter int OFF_W   = 12,
    parameter int FRAME_W = 20,
    parameter int DATA_W  = 8,
    localparam int ADDR_W = FRAME_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_i,
    input  logic [1:0]         reg_sel_i,
    input  logic [CNT_W-1:0]   reg_wdata_i,
    input  logic               map_wr_i,
    input  logic [TAG_W-1:0]   map_idx_i,
    input  logic [FRAME_W-1:0] map_frame_i,
    input  logic               drq_i,
    input  logic               irq_i,
    input  logic [DATA_W-1:0]  dev_rdata_i,
    output logic               dev_rd_o,
    output logic               dev_wr_o,
    output logic [DATA_W-1:0]  dev_wdata_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    output logic               mem_re_o,
    output logic               mem_we_o,
    output logic [DATA_W-1:0]  mem_wdata_o,
    input  logic [DATA_W-1:0]  mem_rdata_i,
    output logic               int_o,
    output logic [ST_W-1:0]    stat_o,
    output logic [CNT_W-1:0]   cnt_o,
    output logic [TAG_W-1:0]   tag_o,
    output logic [OFF_W-1:0]   off_o
);
    logic               go, en, dir, tcz, pend;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   cnt;
    logic [TAG_W-1:0]   tag;
    logic [OFF_W-1:0]   off;

    pmdma_chan_regs #(.CNT_W(CNT_W), .TAG_W(TAG_W), .OFF_W(OFF_W)) u_chan (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_e'(reg_sel_i)), .reg_wdata_i(reg_wdata_i),
        .drq_i(drq_i), .go_o(go), .en_o(en), .dir_o(dir), .tcz_o(tcz),
        .cnt_o(cnt), .tag_o(tag), .off_o(off)
    );

    pmdma_page_map #(.TAG_W(TAG_W), .FRAME_W(FRAME_W)) u_map (
        .clk(clk), .wr_i(map_wr_i), .widx_i(map_idx_i), .wframe_i(map_frame_i),
        .ridx_i(tag), .rframe_o(frame)
    );

    pmdma_irq_relay u_irq (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .pend_o(pend)
    );

    always_comb begin
        mem_addr_o  = {frame, off};
        dev_rd_o    = go && dir;
        mem_we_o    = go && dir;
        mem_wdata_o = dev_rdata_i;
        mem_re_o    = go && !dir;
        dev_wr_o    = go && !dir;
        dev_wdata_o = mem_rdata_i;
        stat_o          = '0;
        stat_o[ST_EN]   = en;
        stat_o[ST_DIR]  = dir;
        stat_o[ST_PEND] = pend;
        stat_o[ST_TCZ]  = tcz;
        int_o = pend;
        cnt_o = cnt;
        tag_o = tag;
        off_o = off;
    end

    p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o || mem_re_o) |-> (drq_i && !reg_wr_i && stat_o[ST_EN] && cnt_o != '0));
    p_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({dev_rd_o, dev_wr_o}) == $countones({mem_we_o, mem_re_o}));
    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_i && !int_o) |=> !int_o);
    p_pend_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_sel_i == 2'd0 && reg_wdata_i[CTRL_RST] && irq_i && int_o) |=> stat_o[ST_PEND]);
endmodule

// File: tb/pmdma_engine_bench.sv
module pmdma_engine_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [23:0] reg_wdata = '0;
    logic        map_wr = 1'b0;
    logic [6:0]  map_idx = '0;
    logic [19:0] map_frame = '0;
    logic        drq = 1'b0;
    logic        irq = 1'b0;
    logic [7:0]  dev_byte = '0;
    logic        dev_rd, dev_wr, mem_re, mem_we, int_o;
    logic [7:0]  dev_wdata, mem_wdata, mem_rdata;
    logic [31:0] mem_addr;
    logic [4:0]  stat;
    logic [23:0] cnt;
    logic [6:0]  tag;
    logic [11:0] off;

    int n_chk = 0, n_fail = 0, n_strobe = 0;
    bit done = 1'b0;

    typedef struct packed { logic [31:0] a; logic [7:0] d; } item_t;
    item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model: read data is a function of the address.
    assign mem_rdata = mem_addr[7:0] ^ mem_addr[19:12];

    pmdma_engine u_pmdma_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
        .map_wr_i(map_wr), .map_idx_i(map_idx), .map_frame_i(map_frame),
        .drq_i(drq), .irq_i(irq), .dev_rdata_i(dev_byte),
        .dev_rd_o(dev_rd), .dev_wr_o(dev_wr), .dev_wdata_o(dev_wdata),
        .mem_addr_o(mem_addr), .mem_re_o(mem_re), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
        .mem_rdata_i(mem_rdata), .int_o(int_o), .stat_o(stat), .cnt_o(cnt), .tag_o(tag), .off_o(off)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [23:0] val);
        step(); reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        step(); reg_wr = 1'b0;
    endtask

    task automatic wr_map(input logic [6:0] idx, input logic [19:0] fr);
        step(); map_wr = 1'b1; map_idx = idx; map_frame = fr;
        step(); map_wr = 1'b0;
    endtask

    task automatic expect_item(input logic [31:0] a, input logic [7:0] d);
        item_t it;
        it.a = a; it.d = d;
        exp_q.push_back(it);
    endtask

    // Scoreboard monitor: every transfer strobe must match the next expected item (R2, R3, R4, R5).
    always @(negedge clk) begin
        if (rst_n && (mem_we || dev_wr)) begin
            item_t it;
            n_strobe++;
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R3: unexpected transfer at 0x%0h, expected none", mem_addr);
            end else begin
                it = exp_q.pop_front();
                if (mem_addr !== it.a) begin
                    n_fail++;
                    $display("FAIL R2: address actual 0x%0h expected 0x%0h", mem_addr, it.a);
                end
                if (mem_we && (mem_wdata !== it.d || !dev_rd || mem_re)) begin
                    n_fail++;
                    $display("FAIL R4: data/strobes actual 0x%0h expected 0x%0h", mem_wdata, it.d);
                end
                if (dev_wr && (dev_wdata !== it.d || !mem_re || dev_rd)) begin
                    n_fail++;
                    $display("FAIL R5: data/strobes actual 0x%0h expected 0x%0h", dev_wdata, it.d);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R12 status", 32'(stat), 32'h0);
        chk("R12 count", 32'(cnt), 32'h0);
        chk("R12 int", 32'(int_o), 32'h0);

        wr_map(7'd5, 20'hABCDE);
        wr_map(7'd6, 20'h12345);
        wr_map(7'd0, 20'h00001);
        wr_map(7'd127, 20'h7F00F);

        // Device to memory, streaming across a page boundary (R1, R4, R6, R7, R8, R11)
        wr_reg(2'd2, 24'd5);
        wr_reg(2'd3, 24'hFFE);
        wr_reg(2'd1, 24'd3);
        wr_reg(2'd0, 24'h3);
        chk("R1 status enabled", 32'(stat), 32'h03);
        base = n_strobe;
        step(); drq = 1'b1; dev_byte = 8'h40; expect_item(32'hABCDEFFE, 8'h40);
        step(); dev_byte = 8'h41; expect_item(32'hABCDEFFF, 8'h41);
        step(); dev_byte = 8'h42; expect_item(32'h12345000, 8'h42);
        step(); drq = 1'b0;
        chk("R11 one byte per clock", 32'(n_strobe - base), 32'd3);
        chk("R8 status done", 32'(stat), 32'h12);
        chk("R8 int unchanged", 32'(int_o), 32'h0);
        chk("R6 count", 32'(cnt), 32'h0);
        chk("R6 offset", 32'(off), 32'h001);
        chk("R7 tag stepped", 32'(tag), 32'd6);

        // Disabled channel ignores requests (R3)
        wr_reg(2'd1, 24'd2);
        wr_reg(2'd0, 24'h2);
        base = n_strobe;
        step(); drq = 1'b1;
        repeat (3) step();
        drq = 1'b0;
        chk("R3 no strobe while disabled", 32'(n_strobe - base), 32'd0);
        chk("R3 count kept", 32'(cnt), 32'd2);

        // Memory to device; register write in the request cycle blocks the byte (R3, R5)
        wr_reg(2'd2, 24'd0);
        wr_reg(2'd3, 24'h010);
        wr_reg(2'd0, 24'h1);
        step(); drq = 1'b1; reg_wr = 1'b1; reg_sel = 2'd3; reg_wdata = 24'h020;
        expect_item(32'h00001020, 8'h21);
        expect_item(32'h00001021, 8'h20);
        step(); reg_wr = 1'b0;
        step();
        step(); drq = 1'b0;
        chk("R5 status done", 32'(stat), 32'h10);
        chk("R3 offset after blocked cycle", 32'(off), 32'h022);

        // Interrupt relay (R9)
        step(); irq = 1'b1;
        chk("R9 int not yet", 32'(int_o), 32'h0);
        step();
        chk("R9 int set", 32'(int_o), 32'h1);
        chk("R9 pending", 32'(stat), 32'h18);

        // Soft reset keeps pending and the page table (R10)
        wr_reg(2'd2, 24'd9);
        wr_reg(2'd3, 24'h123);
        wr_reg(2'd1, 24'd5);
        wr_reg(2'd0, 24'h3);
        wr_reg(2'd0, 24'h4);
        chk("R10 status", 32'(stat), 32'h08);
        chk("R10 count", 32'(cnt), 32'h0);
        chk("R10 tag", 32'(tag), 32'h0);
        chk("R10 offset", 32'(off), 32'h0);
        chk("R10 int kept", 32'(int_o), 32'h1);
        wr_reg(2'd2, 24'd6);
        wr_reg(2'd1, 24'd1);
        wr_reg(2'd0, 24'h3);
        step(); drq = 1'b1; dev_byte = 8'h77; expect_item(32'h12345000, 8'h77);
        step(); drq = 1'b0;
        chk("R10 map kept, single byte done", 32'(stat), 32'h1A);

        step(); irq = 1'b0;
        step();
        chk("R9 int cleared", 32'(int_o), 32'h0);
        chk("R9 pending cleared", 32'(stat), 32'h12);

        // Tag wraps from 127 to 0 (R7)
        wr_reg(2'd2, 24'd127);
        wr_reg(2'd3, 24'hFFF);
        wr_reg(2'd1, 24'd2);
        wr_reg(2'd0, 24'h1);
        step(); drq = 1'b1;
        expect_item(32'h7F00FFFF, 8'hF0);
        expect_item(32'h00001000, 8'h01);
        step();
        step(); drq = 1'b0;
        chk("R7 tag wrapped", 32'(tag), 32'h0);
        chk("R6 offset after wrap", 32'(off), 32'h001);
        chk("R8 status", 32'(stat), 32'h10);

        repeat (2) step();
        chk("R3 scoreboard drained", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule